// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple request/done host port and an external asynchronous static RAM of 64K 16-bit words. The RAM has active-low chip select, write strobe, output enable and one enable per byte lane. Each host transaction carries an address, a write flag, a 2-bit lane mask and write data. The controller turns it into a strobe sequence in which every phase lasts a whole number of clock cycles. The host sees a one-cycle completion pulse and, for reads, the captured word.

Every phase length comes from a picosecond figure and the clock period. The length is rounded up to whole cycles and is never less than one cycle. The controller drives the shared data bus only during writes. After every read it waits out a release window with the RAM outputs disabled, so the two sides never drive the bus together.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset, and whenever no transaction is in flight, chip select, write strobe, output enable and both lane enables are high, and `done_o` is low.
- R2: A read holds chip select low, output enable low and write strobe high for AA_CYC cycles, with lane enable i low exactly when mask bit i is set (bit 0: data bits 7:0, bit 1: data bits 15:8).
- R3: At the end of the access window a read captures each selected lane into `rdata_o`, and it returns zero in each unselected lane. `rdata_o` keeps that value until the next read completes.
- R4: A write holds chip select and write strobe low and output enable high for PULSE_CYC cycles. PULSE_CYC is the largest of the pulse-width, data-setup and cycle-time-minus-one counts. For one further cycle after the write strobe rises, chip select stays low and address, lane enables and data stay unchanged.
- R5: A write changes only the byte lanes whose mask bit is set. Mask 00 completes the handshake and alters no storage.
- R6: The controller drives the data bus only while output enable is high and was also high in the previous cycle. Write strobe and output enable are never low together.
- R7: After every read, chip select, output enable and both lane enables stay high for HZ_CYC cycles before the controller returns to idle.
- R8: `done_o` is high for exactly one cycle, the first idle cycle after a transaction. It rises AA_CYC+HZ_CYC clock edges after the accepting edge of a read and PULSE_CYC+1 edges after the accepting edge of a write.
- R9: A request raised while a transaction is in flight is ignored. It starts no strobe activity and produces no completion.
- R10: Every phase count equals the ceiling of its time divided by the clock period, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request, sampled only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| addr_i | input | 16 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Captured read data, unselected lanes zero |
| done_o | output | 1 | One-cycle completion pulse |
| sram_addr_o | output | 16 | RAM address |
| sram_dq_io | inout | 16 | RAM data bus |
| sram_ce_no | output | 1 | RAM chip select, active low |
| sram_we_no | output | 1 | RAM write strobe, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_be_no | output | 2 | RAM lane enables, active low, bit 0 low byte |

## Verification
The bench's RAM model drives a garbage word until the access count has elapsed. A controller that samples one cycle early therefore returns that garbage instead of the stored data. The model also keeps driving for the release window after output enable rises. A controller without the turnaround, one that starts a write straight after a read, overlaps that window and is reported as contention. Mixed lane masks written back to back and read with other masks expose lane-swap or whole-word-write faults as wrong merged words. A request pulsed mid-transaction must leave the target word and the completion count untouched, which catches a controller that accepts work outside idle.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WR,
    ST_WEND
  } ctl_state_e;

  // ceil(t/clk), floor of one cycle
  function automatic int unsigned to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
`timescale 1ns/1ps
module sram_lane_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_fsm.sv
`timescale 1ns/1ps
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned AA_CYC    = 2,
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned HZ_CYC    = 1,
  parameter int unsigned CW        = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          done_o,
  output logic          ce_no,
  output logic          we_no,
  output logic          oe_no,
  output logic          lane_act_o,
  output logic          drive_o
);

  ctl_state_e state_q, state_d;
  logic       fin;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    fin        = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o   = 1'b1;
        load_o     = 1'b1;
        state_d    = we_i ? ST_WR : ST_RD;
        load_val_o = we_i ? CW'(PULSE_CYC - 1) : CW'(AA_CYC - 1);
      end
      ST_RD: if (zero_i) begin
        capture_o  = 1'b1;
        load_o     = 1'b1;
        load_val_o = CW'(HZ_CYC - 1);
        state_d    = ST_TURN;
      end
      ST_TURN: if (zero_i) begin
        fin     = 1'b1;
        state_d = ST_IDLE;
      end
      ST_WR: if (zero_i) state_d = ST_WEND;
      ST_WEND: begin
        fin     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      done_o     <= 1'b0;
      ce_no      <= 1'b1;
      we_no      <= 1'b1;
      oe_no      <= 1'b1;
      lane_act_o <= 1'b0;
      drive_o    <= 1'b0;
    end else begin
      state_q    <= state_d;
      done_o     <= fin;
      ce_no      <= !(state_d inside {ST_RD, ST_WR, ST_WEND});
      we_no      <= (state_d != ST_WR);
      oe_no      <= (state_d != ST_RD);
      lane_act_o <= (state_d inside {ST_RD, ST_WR, ST_WEND});
      drive_o    <= (state_d inside {ST_WR, ST_WEND});
    end
  end

endmodule

// File: rtl/sram_lane_datapath.sv
`timescale 1ns/1ps
module sram_lane_datapath #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             capture_i,
  input  logic             lane_act_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    bus_i,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic [DW-1:0]    rdata_o,
  output logic [LANES-1:0] be_no
);

  logic [LANES-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      mask_q  <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      mask_q  <= be_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_no[g] = !(lane_act_i && mask_q[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rdata_o[g*8 +: 8] <= '0;
      else if (capture_i) rdata_o[g*8 +: 8] <= mask_q[g] ? bus_i[g*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 16,
  parameter int unsigned CLK_PS = 5000,
  parameter int unsigned T_AA_PS = 10000,
  parameter int unsigned T_WP_PS = 7000,
  parameter int unsigned T_DW_PS = 5000,
  parameter int unsigned T_WC_PS = 10000,
  parameter int unsigned T_HZ_PS = 5000,
  localparam int unsigned LANES = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             done_o,
  output logic [AW-1:0]    sram_addr_o,
  inout  wire  [DW-1:0]    sram_dq_io,
  output logic             sram_ce_no,
  output logic             sram_we_no,
  output logic             sram_oe_no,
  output logic [LANES-1:0] sram_be_no
);

  localparam int unsigned AA_CYC    = to_cyc(T_AA_PS, CLK_PS);
  localparam int unsigned WP_CYC    = to_cyc(T_WP_PS, CLK_PS);
  localparam int unsigned DS_CYC    = to_cyc(T_DW_PS, CLK_PS);
  localparam int unsigned WC_CYC    = to_cyc(T_WC_PS, CLK_PS);
  localparam int unsigned HZ_CYC    = to_cyc(T_HZ_PS, CLK_PS);
  // last cycle (strobe high, data held) completes the write cycle
  localparam int unsigned PULSE_CYC = max3(WP_CYC, DS_CYC, WC_CYC - 1);
  localparam int unsigned CNT_MAX   = max3(AA_CYC, PULSE_CYC, HZ_CYC);
  localparam int unsigned CW        = $clog2(CNT_MAX + 1);

  logic          load, zero, accept, capture, lane_act, drive;
  logic [CW-1:0] load_val;
  logic [DW-1:0] wdata_q;

  sram_lane_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sram_lane_fsm #(
    .AA_CYC    (AA_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HZ_CYC    (HZ_CYC),
    .CW        (CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .done_o     (done_o),
    .ce_no      (sram_ce_no),
    .we_no      (sram_we_no),
    .oe_no      (sram_oe_no),
    .lane_act_o (lane_act),
    .drive_o    (drive)
  );

  sram_lane_datapath #(.AW(AW), .DW(DW), .LANES(LANES)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .lane_act_i (lane_act),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .be_i       (be_i),
    .bus_i      (sram_dq_io),
    .addr_o     (sram_addr_o),
    .wdata_o    (wdata_q),
    .rdata_o    (rdata_o),
    .be_no      (sram_be_no)
  );

  assign sram_dq_io = drive ? wdata_q : {DW{1'bz}};

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk #(
  parameter int unsigned AW     = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned WP_CYC = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             drive,
  input logic [AW-1:0]    sram_addr_o,
  input logic             sram_ce_no,
  input logic             sram_we_no,
  input logic             sram_oe_no,
  input logic [LANES-1:0] sram_be_no
);

  logic [7:0] we_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           we_low_cnt <= '0;
    else if (!sram_we_no)  we_low_cnt <= (we_low_cnt == 8'hff) ? we_low_cnt : we_low_cnt + 1'b1;
    else                   we_low_cnt <= '0;
  end

  p_done_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sram_ce_no && sram_we_no && sram_oe_no));

  p_lane_needs_ce_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_be_no != {LANES{1'b1}}) |-> !sram_ce_no);

  p_we_needs_ce_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no);

  p_hold_after_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> ($stable(sram_addr_o) && $stable(sram_be_no) && !sram_ce_no));

  p_we_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_low_cnt >= WP_CYC));

  p_no_rd_wr_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));

  p_drive_after_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive |-> (sram_oe_no && $past(sram_oe_no)));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .AW     (AW),
  .LANES  (LANES),
  .WP_CYC (WP_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .drive       (drive),
  .sram_addr_o (sram_addr_o),
  .sram_ce_no  (sram_ce_no),
  .sram_we_no  (sram_we_no),
  .sram_oe_no  (sram_oe_no),
  .sram_be_no  (sram_be_no)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;

  localparam int CLK_PS = 5000;
  localparam int AA = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int WP = (7000 + CLK_PS - 1) / CLK_PS;
  localparam int DS = (5000 + CLK_PS - 1) / CLK_PS;
  localparam int WC = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int HZ = (5000 + CLK_PS - 1) / CLK_PS;
  localparam int P0 = (WP > DS) ? WP : DS;
  localparam int PULSE = (P0 > WC - 1) ? P0 : WC - 1;
  // negedges from the request-driving negedge until done is seen
  localparam int RD_LAT = AA + HZ + 1;
  localparam int WR_LAT = PULSE + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [1:0]  be = '0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata, sram_addr;
  logic        done, ce_n, we_n, oe_n;
  logic [1:0]  sram_be_n;
  wire  [15:0] dq;

  int total = 0, bad = 0, contention = 0, hold_bad = 0;

  always #2.5 clk = ~clk;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(wr), .be_i(be),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
    .sram_addr_o(sram_addr), .sram_dq_io(dq), .sram_ce_no(ce_n),
    .sram_we_no(we_n), .sram_oe_no(oe_n), .sram_be_no(sram_be_n)
  );

  // ---------------- RAM model ----------------
  logic [15:0] mdl_mem [256];
  logic [15:0] ref_mem [256];
  int          m_cnt = 0, m_hold = 0;
  logic        m_drv = 1'b0;
  logic [1:0]  m_lanes = '0;
  logic [7:0]  m_addr = '0;
  logic        p_we = 1'b1, p_ce = 1'b1;
  logic [15:0] p_addr = '0, p_dq = '0;
  logic [1:0]  p_lanes = '0;
  logic [15:0] m_val;

  assign m_val    = (m_cnt >= AA) ? mdl_mem[m_addr] : 16'hA5C3;
  assign dq[7:0]  = (m_drv && m_lanes[0]) ? m_val[7:0]  : 8'hzz;
  assign dq[15:8] = (m_drv && m_lanes[1]) ? m_val[15:8] : 8'hzz;

  initial for (int i = 0; i < 256; i++) begin mdl_mem[i] = '0; ref_mem[i] = '0; end

  always @(negedge clk) begin
    if (rst_n) begin
      // controller drives during the strobe-low cycles and the hold cycle after
      if (m_drv && (!we_n || !p_we)) contention++;
      if (!p_we && we_n && !p_ce) begin
        if (sram_addr !== p_addr) hold_bad++;
        for (int l = 0; l < 2; l++)
          if (p_lanes[l]) begin
            if (dq[l*8 +: 8] !== p_dq[l*8 +: 8]) hold_bad++;
            mdl_mem[p_addr[7:0]][l*8 +: 8] = p_dq[l*8 +: 8];
          end
      end
      if (!ce_n && !oe_n && we_n) begin
        m_cnt++; m_addr = sram_addr[7:0]; m_lanes = ~sram_be_n; m_hold = HZ; m_drv = 1'b1;
      end else if (m_hold > 0) begin
        m_hold--; m_drv = 1'b1;
      end else begin
        m_drv = 1'b0; m_cnt = 0; m_lanes = '0;
      end
      p_we = we_n; p_ce = ce_n; p_addr = sram_addr; p_dq = dq; p_lanes = ~sram_be_n;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [15:0] a, input logic [1:0] m);
    return {m[1] ? ref_mem[a[7:0]][15:8] : 8'h00, m[0] ? ref_mem[a[7:0]][7:0] : 8'h00};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction

  task automatic do_op(input bit w, input logic [1:0] m, input logic [15:0] a, input logic [15:0] d);
    int k;
    logic [15:0] expd;
    @(negedge clk);
    req = 1'b1; wr = w; be = m; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; k = 1;
    if (w) check(!ce_n && !we_n && oe_n && (sram_be_n == ~m), "R4 write strobes",
                 {ce_n, we_n, oe_n, sram_be_n}, {3'b001, ~m});
    else   check(!ce_n && we_n && !oe_n && (sram_be_n == ~m), "R2 read strobes",
                 {ce_n, we_n, oe_n, sram_be_n}, {3'b010, ~m});
    while (!done && k < 40) begin
      @(negedge clk); k++;
      if (!w && k == AA + 1)
        check(ce_n && oe_n && (sram_be_n == 2'b11), "R7 turnaround released",
              {ce_n, oe_n, sram_be_n}, 4'hf);
    end
    check(k == (w ? WR_LAT : RD_LAT), "R8 R10 done latency", k, w ? WR_LAT : RD_LAT);
    if (w) ref_mem[a[7:0]] = merge(ref_mem[a[7:0]], d, m);
    else begin
      expd = exp_read(a, m);
      check(rdata == expd, "R3 R5 read data", rdata, expd);
    end
    @(negedge clk);
    check(!done && ce_n && we_n && oe_n, "R8 R1 single done, idle", {done, ce_n, we_n, oe_n}, 4'b0111);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [15:0] keep;
    int k, extra;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(ce_n && we_n && oe_n && sram_be_n == 2'b11 && !done, "R1 reset state",
          {ce_n, we_n, oe_n, sram_be_n, done}, 6'b111110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ce_n && we_n && oe_n && sram_be_n == 2'b11 && !done, "R1 idle after reset",
          {ce_n, we_n, oe_n, sram_be_n, done}, 6'b111110);

    // directed: full word, lane merges, zero mask
    do_op(1'b1, 2'b11, 16'h0010, 16'h1234);
    do_op(1'b0, 2'b11, 16'h0010, 16'h0);
    do_op(1'b1, 2'b01, 16'h0010, 16'hAAAA);   // R5 low lane only
    do_op(1'b1, 2'b10, 16'h0010, 16'h5B5B);   // R5 high lane only
    do_op(1'b0, 2'b11, 16'h0010, 16'h0);
    do_op(1'b0, 2'b10, 16'h0010, 16'h0);      // R3 low lane reads zero
    do_op(1'b0, 2'b01, 16'h0010, 16'h0);
    do_op(1'b1, 2'b00, 16'h0010, 16'hFFFF);   // R5 mask 00 changes nothing
    do_op(1'b0, 2'b11, 16'h0010, 16'h0);
    keep = rdata;
    do_op(1'b1, 2'b11, 16'h0020, 16'h7777);
    check(rdata == keep, "R3 rdata held over write", rdata, keep);
    // read directly followed by write: contention check covers R6/R7
    do_op(1'b0, 2'b11, 16'h0020, 16'h0);
    do_op(1'b1, 2'b11, 16'h0021, 16'h4321);

    // R9: request during a read is ignored
    @(negedge clk);
    req = 1'b1; wr = 1'b0; be = 2'b11; addr = 16'h0010;
    @(negedge clk);
    req = 1'b1; wr = 1'b1; be = 2'b11; addr = 16'h0030; wdata = 16'hDEAD;
    @(negedge clk);
    req = 1'b0; k = 2; extra = 0;
    while (!done && k < 40) begin @(negedge clk); k++; end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done || !we_n || !ce_n) extra++;
    end
    check(extra == 0, "R9 busy request ignored at pins", extra, 0);
    do_op(1'b0, 2'b11, 16'h0030, 16'h0);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [15:0] ra;
      ra = {8'($urandom), 4'h0, 4'($urandom)};
      do_op(1'($urandom), 2'($urandom), ra, 16'($urandom));
    end
    for (int i = 0; i < 16; i++) do_op(1'b0, 2'b11, 16'(i), 16'h0);

    check(contention == 0, "R6 R7 no bus contention", contention, 0);
    check(hold_bad == 0, "R4 address and data held through strobe rise", hold_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule